// File: doc/BRIEF.md
# Indirect Peripheral-Bus Access Bridge

This block is an APB slave register file that gives a processor its only path onto a slower on-chip peripheral bus. Software never addresses the peripheral bus directly. It stages an access in one of two channels: an enable word, a direction word, a size code, a target address and write data. It then writes a separate trigger register. The bridge picks the enabled channel and runs a single 1-, 2- or 4-byte read or write on the peripheral bus. That bus uses a request/acknowledge handshake with an optional error flag.

When a cycle completes, the bridge captures read data into that channel's read-data register and sets that channel's acknowledge bit in an interrupt status register. The interrupt output is high while any acknowledge bit is set. Software clears the bits by writing 1 to them. Further registers hold window offsets and byte-order settings. These take reset values that software can read back.

Top module: `pbridge_top`

## Requirements
- R1: After reset: word 0x00 reads 0x000000A1. The byte-order words read 0x0044EEE4 (0x4C), 0x0055AAFF (0x50), 0x00117717 (0x54), 0xFFAA5500 (0x58), 0x0044EEE4 (0x5C) and 0x00117717 (0x60). The staging registers, status, read-data words and `irq` are 0, and `pb_req` is low.
- R2: An APB write takes effect only when `pstrb` is 4'hF. A write with any other strobe changes no register and does not trigger.
- R3: Staging words read back as written. Channel 0 uses 0x10 (enable), 0x14 (direction), 0x18 (size), 0x1C (address) and 0x20 (write data). Channel 1 uses 0x28, 0x2C, 0x30, 0x34 and 0x38. Word 0x08 keeps only bits 31:13 and word 0x0C keeps only bits 31:22. The byte-order words store what is written.
- R4: A full write to 0x04 starts one bus cycle for the channel whose enable bit 0 is set, choosing channel 0 if both are set. The cycle presents that channel's address, uses direction bit 0 (1 = read) as `pb_rd`, and drives the size code on `pb_size`. `pb_req` rises on the clock edge that completes the APB access.
- R5: A trigger with neither channel enabled issues no bus cycle.
- R6: The size code gives the byte count minus one: 0 is a byte, 1 a halfword, 3 a word. A code of 2, or one with any bit above bit 1 set, issues no bus cycle.
- R7: While `pb_req` is high and `pb_ack` is low, `pb_req`, `pb_addr`, `pb_wdata`, `pb_size` and `pb_rd` hold steady. `pb_req` drops on the edge where `pb_ack` is sampled high.
- R8: Bytes sit in little-endian lanes. Write data is driven with the lanes above the access size set to zero. Read data is captured zero-extended into 0x84 (channel 0) or 0x90 (channel 1), and only on an error-free read.
- R9: An error-free completion sets status bit 16 for channel 0 or bit 17 for channel 1 in word 0x48. A completion with `pb_err` high sets no bit and updates no read data.
- R10: Status bits clear where a 1 is written to them. `irq` is high whenever either acknowledge bit is set.
- R11: A trigger written while a bus cycle is outstanding is ignored.
- R12: Reads of unmapped words, including all offsets above 0xE8, return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write |
| paddr | input | APB_AW | APB byte address |
| pwdata | input | 32 | APB write data |
| pstrb | input | 4 | APB byte strobes; only 4'hF writes |
| prdata | output | 32 | APB read data |
| pb_req | output | 1 | Peripheral-bus request |
| pb_rd | output | 1 | 1 = read, 0 = write |
| pb_size | output | 2 | Byte count minus one |
| pb_addr | output | PB_AW | Peripheral-bus address |
| pb_wdata | output | 32 | Write data, little-endian lanes |
| pb_ack | input | 1 | Slave acknowledge |
| pb_err | input | 1 | Slave error, valid with acknowledge |
| pb_rdata | input | 32 | Slave read data, valid with acknowledge |
| irq | output | 1 | OR of the acknowledge status bits |

## Verification
The bench builds the bridge with its default parameters: a 12-bit APB address and a 32-bit peripheral address. With these settings the whole decoded window, including offsets past 0xE8, and every bit of the target address can be reached. The slave model in the bench answers after 0 to 3 idle cycles, or after a long directed delay. The long delay keeps a cycle open long enough to test a second trigger and to check that the request holds steady. Random traffic mixes both channels, both directions, all three sizes and error responses. Directed cases cover the rejected size codes, the case with no channel enabled, the case with both enabled, and partial-strobe writes.

// File: rtl/pbr_pkg.sv
package pbr_pkg;
  localparam int NCH        = 2;
  localparam int CH_W       = 1;
  localparam int CH_BASE    = 'h10;
  localparam int CH_STRIDE  = 'h18;
  localparam int RD_BASE    = 'h84;
  localparam int RD_STRIDE  = 'h0C;
  localparam int OFF_VER    = 'h00;
  localparam int OFF_TRIG   = 'h04;
  localparam int OFF_CTL    = 'h08;
  localparam int OFF_WIN    = 'h0C;
  localparam int OFF_STS    = 'h48;
  localparam int OFF_BO     = 'h4C;
  localparam int NBO        = 6;
  localparam int ACK_LSB    = 16;
  localparam logic [31:0] VERSION  = 32'h0000_00A1;
  localparam logic [31:0] CTL_MASK = 32'hFFFF_E000;
  localparam logic [31:0] WIN_MASK = 32'hFFC0_0000;

  typedef struct packed {
    logic [31:0] en;
    logic [31:0] dir;
    logic [31:0] size;
    logic [31:0] addr;
    logic [31:0] wdata;
  } chan_cfg_t;

  function automatic logic [31:0] bo_reset(input int idx);
    case (idx)
      0, 4:    return 32'h0044_EEE4;
      1:       return 32'h0055_AAFF;
      2, 5:    return 32'h0011_7717;
      default: return 32'hFFAA_5500;
    endcase
  endfunction

  function automatic logic size_ok(input logic [31:0] code);
    return (code == 32'd0) || (code == 32'd1) || (code == 32'd3);
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] code);
    case (code)
      2'd0:    return 32'h0000_00FF;
      2'd1:    return 32'h0000_FFFF;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/pbr_chan_regs.sv
module pbr_chan_regs
  import pbr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [2:0]  wr_field,
  input  logic [31:0] wr_data,
  input  logic        cap_en,
  input  logic [31:0] cap_data,
  output chan_cfg_t   cfg,
  output logic [31:0] rdata
);
  chan_cfg_t   cfg_d;
  logic [31:0] rdata_d;

  always_comb begin
    cfg_d   = cfg;
    rdata_d = rdata;
    if (wr_en) begin
      case (wr_field)
        3'd0:    cfg_d.en    = wr_data;
        3'd1:    cfg_d.dir   = wr_data;
        3'd2:    cfg_d.size  = wr_data;
        3'd3:    cfg_d.addr  = wr_data;
        default: cfg_d.wdata = wr_data;
      endcase
    end
    if (cap_en) rdata_d = cap_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg   <= '0;
      rdata <= '0;
    end else begin
      cfg   <= cfg_d;
      rdata <= rdata_d;
    end
  end
endmodule

// File: rtl/pbr_bus_master.sv
module pbr_bus_master
  import pbr_pkg::*;
#(
  parameter int PB_AW = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch,
  input  logic [PB_AW-1:0] l_addr,
  input  logic [31:0]      l_wdata,
  input  logic [1:0]       l_code,
  input  logic             l_rd,
  input  logic [CH_W-1:0]  l_ch,
  output logic             pb_req,
  output logic             pb_rd,
  output logic [1:0]       pb_size,
  output logic [PB_AW-1:0] pb_addr,
  output logic [31:0]      pb_wdata,
  input  logic             pb_ack,
  input  logic             pb_err,
  input  logic [31:0]      pb_rdata,
  output logic             done_ok,
  output logic             done_rd,
  output logic [CH_W-1:0]  done_ch,
  output logic [31:0]      done_data
);
  logic             req_d, rd_d;
  logic [1:0]       size_d;
  logic [PB_AW-1:0] addr_d;
  logic [31:0]      wdata_d;
  logic [CH_W-1:0]  ch_q, ch_d;
  logic             fin;

  assign fin = pb_req && pb_ack;

  always_comb begin
    req_d   = pb_req;
    rd_d    = pb_rd;
    size_d  = pb_size;
    addr_d  = pb_addr;
    wdata_d = pb_wdata;
    ch_d    = ch_q;
    if (fin) begin
      req_d = 1'b0;
    end else if (launch && !pb_req) begin
      req_d   = 1'b1;
      rd_d    = l_rd;
      size_d  = l_code;
      addr_d  = l_addr;
      wdata_d = l_wdata & lane_mask(l_code);
      ch_d    = l_ch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pb_req   <= 1'b0;
      pb_rd    <= 1'b0;
      pb_size  <= '0;
      pb_addr  <= '0;
      pb_wdata <= '0;
      ch_q     <= '0;
    end else begin
      pb_req   <= req_d;
      pb_rd    <= rd_d;
      pb_size  <= size_d;
      pb_addr  <= addr_d;
      pb_wdata <= wdata_d;
      ch_q     <= ch_d;
    end
  end

  assign done_ok   = fin && !pb_err;
  assign done_rd   = pb_rd;
  assign done_ch   = ch_q;
  assign done_data = pb_rdata & lane_mask(pb_size);

  // R7: request and its fields hold until acknowledged
  a_r7_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_req && !pb_ack) |=> (pb_req && $stable(pb_addr) && $stable(pb_wdata)
                             && $stable(pb_size) && $stable(pb_rd)));
  // R7: request drops after acknowledge
  a_r7_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (pb_req && pb_ack) |=> !pb_req);
  // R6: a three-byte size never reaches the bus
  a_r6_no_bad_size: assert property (@(posedge clk) disable iff (!rst_n)
    pb_req |-> (pb_size != 2'd2));
endmodule

// File: rtl/pbridge_top.sv
module pbridge_top
  import pbr_pkg::*;
#(
  parameter int APB_AW = 12,
  parameter int PB_AW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [APB_AW-1:0] paddr,
  input  logic [31:0]       pwdata,
  input  logic [3:0]        pstrb,
  output logic [31:0]       prdata,
  output logic              pb_req,
  output logic              pb_rd,
  output logic [1:0]        pb_size,
  output logic [PB_AW-1:0]  pb_addr,
  output logic [31:0]       pb_wdata,
  input  logic              pb_ack,
  input  logic              pb_err,
  input  logic [31:0]       pb_rdata,
  output logic              irq
);
  localparam int CH_SPAN = 20;
  localparam int BO_SPAN = NBO * 4;

  logic            wr_ok, trig_wr;
  logic [31:0]     ctl_q, ctl_d, win_q, win_d, trig_q, trig_d;
  logic [NCH-1:0]  sts_q, sts_d, sts_set, cap_en;
  logic [31:0]     bo_q [NBO];
  logic [31:0]     bo_d [NBO];
  chan_cfg_t       cfg [NCH];
  logic [31:0]     rdd [NCH];
  logic [31:0]     ch_rd [NCH];
  logic            done_ok, done_rd;
  logic [CH_W-1:0] done_ch;
  logic [31:0]     done_data;

  assign wr_ok   = psel && penable && pwrite && (pstrb == 4'hF);
  assign trig_wr = wr_ok && (paddr == APB_AW'(OFF_TRIG));

  // channel staging and read-data capture
  for (genvar g = 0; g < NCH; g++) begin : g_ch
    localparam int BASE = CH_BASE + g * CH_STRIDE;
    localparam int RDO  = RD_BASE + g * RD_STRIDE;
    logic [APB_AW-1:0] rel;
    logic              in_win;
    assign rel    = paddr - APB_AW'(BASE);
    assign in_win = (rel < APB_AW'(CH_SPAN)) && (rel[1:0] == 2'b00);
    assign cap_en[g]  = done_ok && done_rd && (done_ch == CH_W'(g));
    assign sts_set[g] = done_ok && (done_ch == CH_W'(g));

    pbr_chan_regs u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_ok && in_win), .wr_field(rel[4:2]), .wr_data(pwdata),
      .cap_en(cap_en[g]), .cap_data(done_data),
      .cfg(cfg[g]), .rdata(rdd[g])
    );

    always_comb begin
      ch_rd[g] = '0;
      if (in_win) begin
        case (rel[4:2])
          3'd0:    ch_rd[g] = cfg[g].en;
          3'd1:    ch_rd[g] = cfg[g].dir;
          3'd2:    ch_rd[g] = cfg[g].size;
          3'd3:    ch_rd[g] = cfg[g].addr;
          default: ch_rd[g] = cfg[g].wdata;
        endcase
      end else if (paddr == APB_AW'(RDO)) begin
        ch_rd[g] = rdd[g];
      end
    end
  end

  // channel pick: lowest enabled channel wins
  logic            any_en;
  logic [CH_W-1:0] pick;
  chan_cfg_t       pcfg;
  always_comb begin
    any_en = 1'b0;
    pick   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (cfg[i].en[0]) begin
        any_en = 1'b1;
        pick   = CH_W'(i);
      end
    end
    pcfg = cfg[pick];
  end

  pbr_bus_master #(.PB_AW(PB_AW)) u_mst (
    .clk(clk), .rst_n(rst_n),
    .launch(trig_wr && any_en && size_ok(pcfg.size)),
    .l_addr(PB_AW'(pcfg.addr)), .l_wdata(pcfg.wdata),
    .l_code(pcfg.size[1:0]), .l_rd(pcfg.dir[0]), .l_ch(pick),
    .pb_req(pb_req), .pb_rd(pb_rd), .pb_size(pb_size), .pb_addr(pb_addr),
    .pb_wdata(pb_wdata), .pb_ack(pb_ack), .pb_err(pb_err), .pb_rdata(pb_rdata),
    .done_ok(done_ok), .done_rd(done_rd), .done_ch(done_ch), .done_data(done_data)
  );

  // common registers: next state
  logic [APB_AW-1:0] bo_rel;
  logic              bo_win;
  assign bo_rel = paddr - APB_AW'(OFF_BO);
  assign bo_win = (bo_rel < APB_AW'(BO_SPAN)) && (bo_rel[1:0] == 2'b00);

  always_comb begin
    ctl_d  = ctl_q;
    win_d  = win_q;
    trig_d = trig_q;
    sts_d  = sts_q;
    for (int i = 0; i < NBO; i++) bo_d[i] = bo_q[i];
    if (wr_ok) begin
      if (paddr == APB_AW'(OFF_CTL))  ctl_d  = pwdata & CTL_MASK;
      if (paddr == APB_AW'(OFF_WIN))  win_d  = pwdata & WIN_MASK;
      if (paddr == APB_AW'(OFF_TRIG)) trig_d = pwdata;
      if (paddr == APB_AW'(OFF_STS))  sts_d  = sts_q & ~pwdata[ACK_LSB +: NCH];
      if (bo_win) bo_d[bo_rel[4:2]] = pwdata;
    end
    sts_d = sts_d | sts_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= '0;
      win_q  <= '0;
      trig_q <= '0;
      sts_q  <= '0;
      for (int i = 0; i < NBO; i++) bo_q[i] <= bo_reset(i);
    end else begin
      ctl_q  <= ctl_d;
      win_q  <= win_d;
      trig_q <= trig_d;
      sts_q  <= sts_d;
      for (int i = 0; i < NBO; i++) bo_q[i] <= bo_d[i];
    end
  end

  // read mux
  always_comb begin
    prdata = '0;
    if      (paddr == APB_AW'(OFF_VER))  prdata = VERSION;
    else if (paddr == APB_AW'(OFF_TRIG)) prdata = trig_q;
    else if (paddr == APB_AW'(OFF_CTL))  prdata = ctl_q;
    else if (paddr == APB_AW'(OFF_WIN))  prdata = win_q;
    else if (paddr == APB_AW'(OFF_STS))  prdata[ACK_LSB +: NCH] = sts_q;
    else if (bo_win)                     prdata = bo_q[bo_rel[4:2]];
    for (int i = 0; i < NCH; i++) prdata = prdata | ch_rd[i];
  end

  assign irq = |sts_q;

  // R4 / R5: a request only starts from a trigger write
  a_r4_req_from_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pb_req) |-> $past(psel && penable && pwrite && pstrb == 4'hF
                            && paddr == APB_AW'(OFF_TRIG)));
  // R9: an acknowledge bit rises only after an error-free completion
  a_r9_ack_needs_ok: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sts_q[0]) || $rose(sts_q[1])) |-> $past(pb_req && pb_ack && !pb_err));
  // R8: read data changes only after an error-free read completion
  a_r8_rdata_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rdd[0]) || !$stable(rdd[1])) |-> $past(pb_req && pb_ack && !pb_err && pb_rd));
  // R10: interrupt follows status
  a_r10_irq_tracks: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pb_req && pb_ack));
endmodule

// File: tb/tb_pbridge_top.sv
`timescale 1ns/1ps
module tb_pbridge_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [11:0] paddr;
  logic [31:0] pwdata, prdata;
  logic [3:0]  pstrb;
  logic        pb_req, pb_rd, pb_ack, pb_err, irq;
  logic [1:0]  pb_size;
  logic [31:0] pb_addr, pb_wdata, pb_rdata;

  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  pbridge_top dut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
    .pb_req(pb_req), .pb_rd(pb_rd), .pb_size(pb_size), .pb_addr(pb_addr),
    .pb_wdata(pb_wdata), .pb_ack(pb_ack), .pb_err(pb_err), .pb_rdata(pb_rdata),
    .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input logic [1:0] c);
    return (c == 2'd0) ? 32'hFF : (c == 2'd1) ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  // slave model
  int          slv_delay = 0;
  bit          slv_err = 0;
  logic [31:0] slv_rdata = '0;
  int          seen = 0, wcnt = 0;
  bit          track = 0;
  logic [31:0] h_addr, h_wdata;
  logic [1:0]  h_size;
  logic        h_rd;
  int          stab_bad = 0;

  always @(negedge clk) begin
    if (!rst_n) begin
      pb_ack <= 1'b0; pb_err <= 1'b0; pb_rdata <= '0; wcnt = 0; track = 0;
    end else if (pb_ack) begin
      pb_ack <= 1'b0; pb_err <= 1'b0; wcnt = 0; track = 0;
    end else if (pb_req) begin
      if (!track) begin
        track = 1; h_addr = pb_addr; h_wdata = pb_wdata; h_size = pb_size; h_rd = pb_rd;
      end else if (h_addr != pb_addr || h_wdata != pb_wdata || h_size != pb_size || h_rd != pb_rd) begin
        stab_bad++;
      end
      if (wcnt >= slv_delay) begin
        pb_ack <= 1'b1; pb_err <= slv_err; pb_rdata <= slv_rdata; seen++;
      end else wcnt++;
    end
  end

  task automatic apb_wr(input logic [11:0] a, input logic [31:0] d,
                        input logic [3:0] s = 4'hF);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d; pstrb = s;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a; pstrb = 4'h0;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!pb_req && !pb_ack) break;
    end
  endtask

  task automatic stage(input int ch, input logic [31:0] en, input logic [31:0] dir,
                       input logic [31:0] sz, input logic [31:0] a, input logic [31:0] wd);
    logic [11:0] b;
    b = (ch == 0) ? 12'h010 : 12'h028;
    apb_wr(b, en); apb_wr(b + 12'h4, dir); apb_wr(b + 12'h8, sz);
    apb_wr(b + 12'hC, a); apb_wr(b + 12'h10, wd);
  endtask

  bit done = 0;
  initial begin
    for (int i = 0; i < 200000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] r, r2;
    int s0;
    logic [31:0] bo_exp [6];
    bo_exp = '{32'h0044EEE4, 32'h0055AAFF, 32'h00117717, 32'hFFAA5500,
               32'h0044EEE4, 32'h00117717};
    void'($urandom(32'd1234));
    psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0; pstrb = '0;
    rst_n = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    apb_rd(12'h000, r); chk(r == 32'hA1, "R1 version", r, 32'hA1);
    for (int i = 0; i < 6; i++) begin
      apb_rd(12'(12'h04C + 4*i), r); chk(r == bo_exp[i], "R1 byte-order", r, bo_exp[i]);
    end
    apb_rd(12'h048, r); chk(r == 0, "R1 status", r, 0);
    apb_rd(12'h084, r); chk(r == 0, "R1 rdata0", r, 0);
    apb_rd(12'h01C, r); chk(r == 0, "R1 addr0", r, 0);
    chk(!irq && !pb_req, "R1 irq/req", {30'd0, irq, pb_req}, 0);

    // R3 readback and masking
    apb_wr(12'h008, 32'hFFFF_FFFF); apb_rd(12'h008, r);
    chk(r == 32'hFFFF_E000, "R3 control mask", r, 32'hFFFF_E000);
    apb_wr(12'h00C, 32'hFFFF_FFFF); apb_rd(12'h00C, r);
    chk(r == 32'hFFC0_0000, "R3 window mask", r, 32'hFFC0_0000);
    apb_wr(12'h058, 32'h1234_5678); apb_rd(12'h058, r);
    chk(r == 32'h1234_5678, "R3 byte-order store", r, 32'h1234_5678);
    apb_wr(12'h034, 32'hCAFE_0001); apb_rd(12'h034, r);
    chk(r == 32'hCAFE_0001, "R3 addr1 store", r, 32'hCAFE_0001);

    // R2 partial strobe ignored
    apb_wr(12'h034, 32'h0BAD_0BAD, 4'h3); apb_rd(12'h034, r);
    chk(r == 32'hCAFE_0001, "R2 partial write", r, 32'hCAFE_0001);

    // R12 unmapped
    apb_rd(12'h0E0, r); chk(r == 0, "R12 unmapped 0xE0", r, 0);
    apb_rd(12'h100, r); chk(r == 0, "R12 beyond 0xE8", r, 0);

    // R5 neither enabled
    stage(0, 0, 1, 3, 32'h100, 32'h0); stage(1, 0, 1, 3, 32'h200, 32'h0);
    s0 = seen; apb_wr(12'h004, 1); repeat (6) @(negedge clk);
    chk(seen == s0, "R5 no channel", seen, s0);

    // R6 bad sizes
    stage(0, 1, 1, 2, 32'h100, 0); apb_wr(12'h004, 1); repeat (6) @(negedge clk);
    chk(seen == s0, "R6 size 2 rejected", seen, s0);
    apb_wr(12'h018, 32'h4); apb_wr(12'h004, 1); repeat (6) @(negedge clk);
    chk(seen == s0, "R6 size 4 rejected", seen, s0);

    // R2 partial strobe trigger ignored
    apb_wr(12'h018, 32'h3); apb_wr(12'h004, 1, 4'h1); repeat (6) @(negedge clk);
    chk(seen == s0, "R2 partial trigger", seen, s0);

    // R4 both enabled -> channel 0; R11 busy trigger ignored; R7 held stable
    stage(1, 1, 1, 3, 32'h0000_2222, 0);
    apb_wr(12'h01C, 32'h0000_1111);
    slv_delay = 8; slv_err = 0; slv_rdata = 32'hA5A5_5A5A;
    apb_wr(12'h004, 1);
    chk(pb_req == 1, "R4 req after trigger", pb_req, 1);
    chk(pb_addr == 32'h1111, "R4 channel 0 wins", pb_addr, 32'h1111);
    apb_wr(12'h004, 1);
    wait_idle(); repeat (3) @(negedge clk);
    chk(seen == s0 + 1, "R11 busy trigger ignored", seen, s0 + 1);
    chk(stab_bad == 0, "R7 fields stable", stab_bad, 0);
    apb_rd(12'h084, r); chk(r == 32'hA5A5_5A5A, "R8 word read ch0", r, 32'hA5A5_5A5A);
    apb_rd(12'h048, r); chk(r == 32'h0001_0000, "R9 ack ch0", r, 32'h0001_0000);
    chk(irq == 1, "R10 irq set", irq, 1);

    // R10 W1C only clears written bits
    apb_wr(12'h010, 0); apb_wr(12'h02C, 0);
    slv_delay = 0; apb_wr(12'h004, 1); wait_idle();
    apb_rd(12'h048, r); chk(r == 32'h0003_0000, "R9 ack ch1", r, 32'h0003_0000);
    apb_wr(12'h048, 32'h0001_0000); apb_rd(12'h048, r);
    chk(r == 32'h0002_0000, "R10 clear one bit", r, 32'h0002_0000);
    apb_wr(12'h048, 32'h0002_0000); @(negedge clk);
    chk(irq == 0, "R10 irq clear", irq, 0);

    // R9 error completion
    apb_rd(12'h090, r2);
    stage(1, 1, 1, 3, 32'h300, 0);
    slv_err = 1; slv_rdata = 32'hDEAD_BEEF; apb_wr(12'h004, 1); wait_idle();
    apb_rd(12'h090, r); chk(r == r2, "R9 error keeps rdata", r, r2);
    apb_rd(12'h048, r); chk(r == 0, "R9 error no ack", r, 0);
    slv_err = 0;

    // random traffic
    for (int it = 0; it < 60; it++) begin
      int ch; logic rd; logic [1:0] code; logic [31:0] a, wd, rdv, old, exp_rd;
      bit er; int base_seen;
      ch = $urandom % 2; rd = 1'($urandom % 2);
      code = ($urandom % 3 == 0) ? 2'd0 : ($urandom % 2 == 0) ? 2'd1 : 2'd3;
      a = $urandom; wd = $urandom; rdv = $urandom; er = ($urandom % 5 == 0);
      slv_delay = $urandom % 4; slv_err = er; slv_rdata = rdv;
      stage(ch, 1, {31'd0, rd}, {30'd0, code}, a, wd);
      stage(1 - ch, 0, 0, 0, 0, 0);
      apb_rd((ch == 0) ? 12'h084 : 12'h090, old);
      base_seen = seen;
      apb_wr(12'h004, 1);
      chk(pb_addr == a && pb_rd == rd && pb_size == code, "R4 random fields",
          pb_addr, a);
      chk(pb_wdata == (wd & mask_of(code)), "R8 write lanes", pb_wdata, wd & mask_of(code));
      wait_idle();
      chk(seen == base_seen + 1, "R4 one cycle", seen, base_seen + 1);
      exp_rd = (rd && !er) ? (rdv & mask_of(code)) : old;
      apb_rd((ch == 0) ? 12'h084 : 12'h090, r);
      chk(r == exp_rd, "R8 read capture", r, exp_rd);
      apb_rd(12'h048, r);
      chk(r == (er ? 32'h0 : (32'h1 << (16 + ch))), "R9 random ack", r,
          er ? 32'h0 : (32'h1 << (16 + ch)));
      chk(irq == !er, "R10 random irq", irq, !er);
      apb_wr(12'h048, 32'h0003_0000);
    end
    chk(stab_bad == 0, "R7 random stability", stab_bad, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule